// File: doc/BRIEF.md
# Control-Word Register Access Decoder

This block sits behind a byte-level I2C target front end and converts packets into accesses on a simple register port. The front end delivers received bytes with a valid strobe, plus one-cycle strobes for start, repeated start and stop. For reads it pulls outgoing bytes on a take strobe. Each packet opens with the target address in write direction and three control-word bytes. The control word carries the direction, a CRC enable, a payload length code, a sector, a page and a 12-bit register address.

A write packet goes on with its payload bytes and, when CRC is enabled, a trailing CRC-8 byte. The block commits the write only at the stop condition, and only if the byte count, the CRC and the sector/page all check out. Otherwise it emits a one-cycle discard pulse with a cause code. A read packet sends a repeated start and then the target address in read direction. The block fetches the register, raises a clock-stretch request until the data arrives, and then serves the data bytes followed by an optional CRC byte.

Top module: `cw_reg_decoder`

## Requirements
- R1: The first byte after a start must equal {TARGET_ADDR, 0}. Any other value makes the block ignore the rest of the packet: no write, no read and no discard.
- R2: The control word arrives most significant byte first. Bit 23 is the operation (1 = read), bit 22 enables CRC, bits 21:20 are the length code (00 = 2 bytes, 01 = 4 bytes, 10 and 11 = 8 bytes), bits 19:16 are the sector, bits 15:12 are the page and bits 11:0 are presented on reg_addr.
- R3: Payload bytes arrive least significant byte first. Byte k lands in reg_wdata[8k+7:8k], and lanes beyond the length read as zero. A valid write shows reg_wr_en high for exactly one cycle, the cycle after the stop strobe.
- R4: If the byte count after the control word differs from the length plus one when CRC is on (plus zero when it is off), the write is dropped with discard cause 1.
- R5: The CRC-8 uses polynomial 0x07 and start value 0xFF and processes each byte MSB first. It covers the write address byte, the three control bytes and the payload bytes. With CRC on, a mismatching final byte drops the write with discard cause 2.
- R6: A nonzero sector or page drops the access with discard cause 3. This cause takes priority over causes 1 and 2. An illegal read issues no reg_rd_en and serves only 0xFF bytes.
- R7: A discard is a single-cycle discard_valid pulse with a nonzero cause. For writes it comes one cycle after the stop; for illegal reads it comes one cycle after the read address byte.
- R8: For a read, the control word is followed by a repeated start and the byte {TARGET_ADDR, 1}. reg_rd_en pulses for one cycle right after that byte, and stretch stays high from that cycle until reg_rd_valid is seen.
- R9: Read bytes come out on tx_byte least significant byte first. When CRC is on, the CRC follows; it continues from the state after the control word over the data bytes. After that the block serves 0xFF. Each tx_take advances by one byte.
- R10: A stop before the control word is complete leaves no write and no discard. A start in the middle of a packet discards all framing, so a following complete packet behaves as if alone.
- R11: reg_wr_en and reg_rd_en are never high in the same cycle, and write packets never issue reg_rd_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | One-cycle strobe, rx_byte holds a received byte |
| rx_byte | input | 8 | Received byte |
| bus_start | input | 1 | Start condition strobe |
| bus_rstart | input | 1 | Repeated start strobe |
| bus_stop | input | 1 | Stop condition strobe |
| tx_take | input | 1 | Front end consumed tx_byte, advance |
| tx_byte | output | 8 | Byte to transmit on a read |
| stretch | output | 1 | Request to hold the bus clock low |
| reg_wr_en | output | 1 | Register write pulse |
| reg_rd_en | output | 1 | Register read request pulse |
| reg_addr | output | 12 | Register address |
| reg_wdata | output | DATA_W | Write data |
| reg_rd_valid | input | 1 | Read data present on reg_rdata |
| reg_rdata | input | DATA_W | Read data |
| discard_valid | output | 1 | Discard pulse |
| discard_cause | output | 2 | Discard cause: 1 length, 2 CRC, 3 sector/page |

## Verification
The properties assume that every front-end strobe lasts exactly one cycle and that rx_valid never shares a cycle with start, repeated start or stop. They also assume that reg_rd_valid answers only a pending read and that tx_take arrives only while bytes are being served. The bench drives each byte or strobe as a one-cycle pulse separated by an idle cycle. It returns read data only once stretch is high and the request pulse has passed, and it pulls read bytes only after the data has been delivered.

// File: rtl/cwdec_pkg.sv
package cwdec_pkg;

   typedef enum logic [1:0] {
      CAUSE_NONE = 2'd0,
      CAUSE_LEN  = 2'd1,
      CAUSE_CRC  = 2'd2,
      CAUSE_SECT = 2'd3
   } cause_e;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_ADDR,
      PH_CTRL,
      PH_DATA,
      PH_RWAIT,
      PH_RADDR,
      PH_SKIP
   } phase_e;

   typedef enum logic [1:0] {
      RS_IDLE,
      RS_FETCH,
      RS_SEND
   } rstate_e;

   typedef struct packed {
      logic        op_rd;
      logic        crc_on;
      logic [1:0]  len;
      logic [3:0]  sect;
      logic [3:0]  page;
      logic [11:0] addr;
   } ctrl_t;

   function automatic logic [7:0] crc8_step(input logic [7:0] c,
                                            input logic [7:0] d,
                                            input logic [7:0] poly);
      logic [7:0] r;
      r = c ^ d;
      for (int i = 0; i < 8; i++) begin
         r = r[7] ? ({r[6:0], 1'b0} ^ poly) : {r[6:0], 1'b0};
      end
      return r;
   endfunction

   function automatic logic [3:0] len_bytes(input logic [1:0] code);
      case (code)
         2'b00:   return 4'd2;
         2'b01:   return 4'd4;
         default: return 4'd8;
      endcase
   endfunction

endpackage

// File: rtl/cwdec_framer.sv
module cwdec_framer
   import cwdec_pkg::*;
#(
   parameter logic [6:0]  TARGET_ADDR = 7'h01,
   parameter logic [7:0]  CRC_POLY    = 8'h07,
   parameter logic [7:0]  CRC_SEED    = 8'hFF,
   parameter int unsigned CNT_W       = 4,
   parameter int unsigned DATA_W      = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_valid,
   input  logic [7:0]        rx_byte,
   input  logic              bus_start,
   input  logic              bus_rstart,
   input  logic              bus_stop,
   output logic              wr_en,
   output logic [11:0]       addr,
   output logic [DATA_W-1:0] wdata,
   output logic [1:0]        len_code,
   output logic              crc_on,
   output logic              rd_go,
   output logic              rd_ok,
   output logic [7:0]        rd_seed,
   output logic              disc_valid,
   output cause_e            disc_cause
);

   localparam int unsigned NB = DATA_W / 8;
   localparam int unsigned LW = $clog2(NB);

   phase_e                phase_q;
   ctrl_t                 ctrl_q;
   ctrl_t                 ctrl_nx;
   logic [CNT_W-1:0]      cnt_q;
   logic [7:0]            crc_q;
   logic [7:0]            crc_rx_q;
   logic [NB-1:0][7:0]    lane_q;

   logic [7:0]            crc_nx;
   logic [CNT_W-1:0]      cnt_inc;
   logic [CNT_W-1:0]      need;
   logic [CNT_W-1:0]      expect_cnt;
   logic                  sect_bad;

   assign ctrl_nx    = ctrl_t'({ctrl_q[15:0], rx_byte});
   assign crc_nx     = crc8_step(crc_q, rx_byte, CRC_POLY);
   assign cnt_inc    = (&cnt_q) ? cnt_q : cnt_q + 1'b1;
   assign need       = CNT_W'(len_bytes(ctrl_q.len));
   assign expect_cnt = need + CNT_W'(ctrl_q.crc_on);
   assign sect_bad   = (|ctrl_q.sect) | (|ctrl_q.page);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q    <= PH_IDLE;
         ctrl_q     <= '0;
         cnt_q      <= '0;
         crc_q      <= CRC_SEED;
         crc_rx_q   <= '0;
         lane_q     <= '0;
         wr_en      <= 1'b0;
         rd_go      <= 1'b0;
         rd_ok      <= 1'b0;
         disc_valid <= 1'b0;
         disc_cause <= CAUSE_NONE;
      end else begin
         wr_en      <= 1'b0;
         rd_go      <= 1'b0;
         disc_valid <= 1'b0;
         disc_cause <= CAUSE_NONE;
         if (bus_start || (bus_rstart && phase_q != PH_RWAIT)) begin
            phase_q <= PH_ADDR;
            cnt_q   <= '0;
            crc_q   <= CRC_SEED;
            lane_q  <= '0;
         end else if (bus_rstart) begin
            phase_q <= PH_RADDR;
         end else if (bus_stop) begin
            phase_q <= PH_IDLE;
            if (phase_q == PH_DATA) begin
               if (sect_bad) begin
                  disc_valid <= 1'b1;
                  disc_cause <= CAUSE_SECT;
               end else if (cnt_q != expect_cnt) begin
                  disc_valid <= 1'b1;
                  disc_cause <= CAUSE_LEN;
               end else if (ctrl_q.crc_on && crc_rx_q != crc_q) begin
                  disc_valid <= 1'b1;
                  disc_cause <= CAUSE_CRC;
               end else begin
                  wr_en <= 1'b1;
               end
            end
         end else if (rx_valid) begin
            case (phase_q)
               PH_ADDR: begin
                  if (rx_byte == {TARGET_ADDR, 1'b0}) begin
                     phase_q <= PH_CTRL;
                     crc_q   <= crc_nx;
                  end else begin
                     phase_q <= PH_SKIP;
                  end
               end
               PH_CTRL: begin
                  ctrl_q <= ctrl_nx;
                  crc_q  <= crc_nx;
                  if (cnt_q == CNT_W'(2)) begin
                     cnt_q   <= '0;
                     phase_q <= ctrl_nx.op_rd ? PH_RWAIT : PH_DATA;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
               PH_DATA: begin
                  if (cnt_q < need) begin
                     lane_q[cnt_q[LW-1:0]] <= rx_byte;
                     crc_q                 <= crc_nx;
                  end else if (cnt_q == need) begin
                     crc_rx_q <= rx_byte;
                  end
                  cnt_q <= cnt_inc;
               end
               PH_RADDR: begin
                  phase_q <= PH_SKIP;
                  if (rx_byte == {TARGET_ADDR, 1'b1} && ctrl_q.op_rd) begin
                     rd_go <= 1'b1;
                     rd_ok <= ~sect_bad;
                     if (sect_bad) begin
                        disc_valid <= 1'b1;
                        disc_cause <= CAUSE_SECT;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   for (genvar g = 0; g < NB; g++) begin : g_lane
      assign wdata[8*g +: 8] = lane_q[g];
   end

   assign addr     = ctrl_q.addr;
   assign len_code = ctrl_q.len;
   assign crc_on   = ctrl_q.crc_on;
   assign rd_seed  = crc_q;

endmodule

// File: rtl/cwdec_rd_path.sv
module cwdec_rd_path
   import cwdec_pkg::*;
#(
   parameter logic [7:0]  CRC_POLY = 8'h07,
   parameter int unsigned CNT_W    = 4,
   parameter int unsigned DATA_W   = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_start,
   input  logic              bus_rstart,
   input  logic              bus_stop,
   input  logic              rd_go,
   input  logic              rd_ok,
   input  logic [7:0]        seed,
   input  logic [1:0]        len_code,
   input  logic              crc_on,
   input  logic              rd_valid,
   input  logic [DATA_W-1:0] rdata,
   input  logic              tx_take,
   output logic              rd_en,
   output logic              hold,
   output logic [7:0]        tx_byte
);

   localparam int unsigned MAXB = 8;
   localparam int unsigned LW   = $clog2(MAXB);

   rstate_e               st_q;
   logic                  bad_q;
   logic                  crc_on_q;
   logic [CNT_W-1:0]      need_q;
   logic [CNT_W-1:0]      idx_q;
   logic [7:0]            seed_q;
   logic [7:0]            crc_q;
   logic [MAXB-1:0][7:0]  lane_q;
   logic [MAXB:0][7:0]    chain;
   logic [7:0]            crc_sel;

   assign chain[0] = seed_q;
   for (genvar g = 0; g < MAXB; g++) begin : g_chain
      assign chain[g+1] = crc8_step(chain[g], rdata[8*g +: 8], CRC_POLY);
   end

   always_comb begin
      case (need_q)
         CNT_W'(2): crc_sel = chain[2];
         CNT_W'(4): crc_sel = chain[4];
         default:   crc_sel = chain[MAXB];
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= RS_IDLE;
         bad_q    <= 1'b0;
         crc_on_q <= 1'b0;
         need_q   <= '0;
         idx_q    <= '0;
         seed_q   <= '0;
         crc_q    <= '0;
         lane_q   <= '0;
      end else if (bus_start || bus_rstart || bus_stop) begin
         st_q <= RS_IDLE;
      end else begin
         case (st_q)
            RS_IDLE: begin
               if (rd_go) begin
                  st_q     <= rd_ok ? RS_FETCH : RS_SEND;
                  bad_q    <= ~rd_ok;
                  crc_on_q <= crc_on;
                  need_q   <= CNT_W'(len_bytes(len_code));
                  seed_q   <= seed;
                  idx_q    <= '0;
               end
            end
            RS_FETCH: begin
               if (rd_valid) begin
                  for (int b = 0; b < MAXB; b++) lane_q[b] <= rdata[8*b +: 8];
                  crc_q <= crc_sel;
                  st_q  <= RS_SEND;
               end
            end
            RS_SEND: begin
               if (tx_take && !(&idx_q)) idx_q <= idx_q + 1'b1;
            end
            default: st_q <= RS_IDLE;
         endcase
      end
   end

   always_comb begin
      tx_byte = 8'hFF;
      if (st_q == RS_SEND && !bad_q) begin
         if (idx_q < need_q)                 tx_byte = lane_q[idx_q[LW-1:0]];
         else if (idx_q == need_q && crc_on_q) tx_byte = crc_q;
      end
   end

   assign rd_en = rd_go & rd_ok;
   assign hold  = rd_en | (st_q == RS_FETCH);

endmodule

// File: rtl/cw_reg_decoder.sv
module cw_reg_decoder
   import cwdec_pkg::*;
#(
   parameter logic [6:0]  TARGET_ADDR = 7'h2A,
   parameter logic [7:0]  CRC_POLY    = 8'h07,
   parameter logic [7:0]  CRC_SEED    = 8'hFF,
   parameter int unsigned CNT_W       = 4,
   parameter int unsigned DATA_W      = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_valid,
   input  logic [7:0]        rx_byte,
   input  logic              bus_start,
   input  logic              bus_rstart,
   input  logic              bus_stop,
   input  logic              tx_take,
   output logic [7:0]        tx_byte,
   output logic              stretch,
   output logic              reg_wr_en,
   output logic              reg_rd_en,
   output logic [11:0]       reg_addr,
   output logic [DATA_W-1:0] reg_wdata,
   input  logic              reg_rd_valid,
   input  logic [DATA_W-1:0] reg_rdata,
   output logic              discard_valid,
   output logic [1:0]        discard_cause
);

   if (DATA_W != 64) begin : g_bad_width
      $error("DATA_W must be 64: the longest payload is eight bytes");
   end
   if (CNT_W < 4) begin : g_bad_cnt
      $error("CNT_W must hold a count above nine bytes");
   end

   logic       rd_go;
   logic       rd_ok;
   logic [7:0] rd_seed;
   logic [1:0] len_code;
   logic       crc_on;
   cause_e     cause;

   cwdec_framer #(
      .TARGET_ADDR (TARGET_ADDR),
      .CRC_POLY    (CRC_POLY),
      .CRC_SEED    (CRC_SEED),
      .CNT_W       (CNT_W),
      .DATA_W      (DATA_W)
   ) i_framer (
      .clk        (clk),
      .rst_n      (rst_n),
      .rx_valid   (rx_valid),
      .rx_byte    (rx_byte),
      .bus_start  (bus_start),
      .bus_rstart (bus_rstart),
      .bus_stop   (bus_stop),
      .wr_en      (reg_wr_en),
      .addr       (reg_addr),
      .wdata      (reg_wdata),
      .len_code   (len_code),
      .crc_on     (crc_on),
      .rd_go      (rd_go),
      .rd_ok      (rd_ok),
      .rd_seed    (rd_seed),
      .disc_valid (discard_valid),
      .disc_cause (cause)
   );

   cwdec_rd_path #(
      .CRC_POLY (CRC_POLY),
      .CNT_W    (CNT_W),
      .DATA_W   (DATA_W)
   ) i_rd_path (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_start  (bus_start),
      .bus_rstart (bus_rstart),
      .bus_stop   (bus_stop),
      .rd_go      (rd_go),
      .rd_ok      (rd_ok),
      .seed       (rd_seed),
      .len_code   (len_code),
      .crc_on     (crc_on),
      .rd_valid   (reg_rd_valid),
      .rdata      (reg_rdata),
      .tx_take    (tx_take),
      .rd_en      (reg_rd_en),
      .hold       (stretch),
      .tx_byte    (tx_byte)
   );

   assign discard_cause = cause;

endmodule

// File: rtl/cwdec_checks.sv
module cwdec_checks (
   input logic       clk,
   input logic       rst_n,
   input logic       bus_start,
   input logic       bus_rstart,
   input logic       bus_stop,
   input logic       reg_wr_en,
   input logic       reg_rd_en,
   input logic       reg_rd_valid,
   input logic       stretch,
   input logic       discard_valid,
   input logic [1:0] discard_cause
);

   p_wr_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr_en |=> !reg_wr_en);

   p_wr_after_stop_r3: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr_en |-> $past(bus_stop));

   p_no_wr_on_disc_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_wr_en && discard_valid));

   p_no_rd_on_disc_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_rd_en && discard_valid));

   p_disc_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
      discard_valid |=> !discard_valid);

   p_disc_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
      discard_valid |-> discard_cause != 2'd0);

   p_rd_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rd_en |=> !reg_rd_en);

   p_rd_stretch_r8: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rd_en |-> stretch);

   p_hold_until_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (stretch && !reg_rd_valid && !bus_start && !bus_rstart && !bus_stop) |=> stretch);

   p_wr_rd_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_wr_en && reg_rd_en));

endmodule

bind cw_reg_decoder cwdec_checks i_checks (
   .clk           (clk),
   .rst_n         (rst_n),
   .bus_start     (bus_start),
   .bus_rstart    (bus_rstart),
   .bus_stop      (bus_stop),
   .reg_wr_en     (reg_wr_en),
   .reg_rd_en     (reg_rd_en),
   .reg_rd_valid  (reg_rd_valid),
   .stretch       (stretch),
   .discard_valid (discard_valid),
   .discard_cause (discard_cause)
);

// File: tb/test_cw_reg_decoder.sv
`timescale 1ns/1ps
module test_cw_reg_decoder;

   localparam logic [6:0] TADDR = 7'h2A;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rx_valid = 1'b0;
   logic [7:0]  rx_byte = 8'h00;
   logic        bus_start = 1'b0;
   logic        bus_rstart = 1'b0;
   logic        bus_stop = 1'b0;
   logic        tx_take = 1'b0;
   logic        reg_rd_valid = 1'b0;
   logic [63:0] reg_rdata = '0;
   logic [7:0]  tx_byte;
   logic        stretch;
   logic        reg_wr_en;
   logic        reg_rd_en;
   logic [11:0] reg_addr;
   logic [63:0] reg_wdata;
   logic        discard_valid;
   logic [1:0]  discard_cause;

   int checks = 0;
   int errors = 0;
   int wr_cnt = 0;
   int rd_cnt = 0;
   int disc_cnt = 0;
   logic [11:0] wr_addr;
   logic [63:0] wr_data;
   logic [1:0]  disc_code;

   always #2.5 clk = ~clk;

   cw_reg_decoder #(.TARGET_ADDR(TADDR)) i_cw_reg_decoder (
      .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
      .bus_start(bus_start), .bus_rstart(bus_rstart), .bus_stop(bus_stop),
      .tx_take(tx_take), .tx_byte(tx_byte), .stretch(stretch),
      .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rd_valid(reg_rd_valid), .reg_rdata(reg_rdata),
      .discard_valid(discard_valid), .discard_cause(discard_cause)
   );

   always @(negedge clk) begin
      if (rst_n) begin
         if (reg_wr_en) begin wr_cnt++; wr_addr = reg_addr; wr_data = reg_wdata; end
         if (reg_rd_en) rd_cnt++;
         if (discard_valid) begin disc_cnt++; disc_code = discard_cause; end
      end
   end

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] crc_b(input logic [7:0] c, input logic [7:0] d);
      logic [7:0] r;
      r = c ^ d;
      for (int i = 0; i < 8; i++) r = r[7] ? ({r[6:0], 1'b0} ^ 8'h07) : {r[6:0], 1'b0};
      return r;
   endfunction

   function automatic int len_of(input logic [1:0] code);
      return (code == 2'b00) ? 2 : (code == 2'b01) ? 4 : 8;
   endfunction

   task automatic put(input logic [7:0] b);
      @(negedge clk); rx_byte = b; rx_valid = 1'b1;
      @(negedge clk); rx_valid = 1'b0;
   endtask

   task automatic do_start();  @(negedge clk); bus_start = 1'b1;  @(negedge clk); bus_start = 1'b0;  endtask
   task automatic do_rstart(); @(negedge clk); bus_rstart = 1'b1; @(negedge clk); bus_rstart = 1'b0; endtask
   task automatic do_stop();   @(negedge clk); bus_stop = 1'b1;   @(negedge clk); bus_stop = 1'b0;   endtask
   task automatic do_take();   @(negedge clk); tx_take = 1'b1;    @(negedge clk); tx_take = 1'b0;    endtask

   task automatic clear();
      @(negedge clk); wr_cnt = 0; rd_cnt = 0; disc_cnt = 0;
   endtask

   // write packet: nb bytes follow the control word
   task automatic wr_pkt(input logic [11:0] a, input logic [3:0] sect, input logic [3:0] page,
                         input logic [1:0] len, input logic crcen, input int nb,
                         input bit bad_crc, input int seed);
      logic [7:0]  c;
      logic [23:0] cw;
      logic [63:0] exp_data;
      logic [7:0]  b;
      int          need;
      int          code;
      c = 8'hFF; exp_data = '0; need = len_of(len);
      cw = {1'b0, crcen, len, sect, page, a};
      clear();
      do_start();
      put({TADDR, 1'b0}); c = crc_b(c, {TADDR, 1'b0});
      for (int k = 2; k >= 0; k--) begin put(cw[8*k +: 8]); c = crc_b(c, cw[8*k +: 8]); end
      for (int k = 0; k < nb; k++) begin
         b = 8'((seed * 37 + k * 11 + 5) & 255);
         if (k < need) begin
            put(b); c = crc_b(c, b);
            exp_data[8*k +: 8] = b;
         end else if (k == need && crcen) begin
            put(bad_crc ? (c ^ 8'h01) : c);
         end else begin
            put(b);
         end
      end
      do_stop();
      @(negedge clk); @(negedge clk);
      if (sect != 0 || page != 0)          code = 3;
      else if (nb != need + int'(crcen))   code = 1;
      else if (crcen && bad_crc)           code = 2;
      else                                 code = 0;
      chk(rd_cnt == 0, "R11 no read on write packet", 64'(rd_cnt), 0);
      if (code == 0) begin
         chk(wr_cnt == 1 && disc_cnt == 0, "R3 write committed", 64'(wr_cnt), 1);
         chk(wr_addr == a, "R2 write address", 64'(wr_addr), 64'(a));
         chk(wr_data == exp_data, "R3 write data lanes", wr_data, exp_data);
      end else begin
         chk(wr_cnt == 0, "R4 R5 R6 write suppressed", 64'(wr_cnt), 0);
         chk(disc_cnt == 1 && disc_code == 2'(code), "R7 discard cause",
             64'(disc_code), 64'(code));
      end
   endtask

   task automatic rd_pkt(input logic [11:0] a, input logic [3:0] sect, input logic [3:0] page,
                         input logic [1:0] len, input logic crcen, input logic [63:0] data);
      logic [7:0]  c;
      logic [23:0] cw;
      logic [7:0]  exp;
      int          need;
      bit          ok;
      c = 8'hFF; need = len_of(len); ok = (sect == 0 && page == 0);
      cw = {1'b1, crcen, len, sect, page, a};
      clear();
      do_start();
      put({TADDR, 1'b0}); c = crc_b(c, {TADDR, 1'b0});
      for (int k = 2; k >= 0; k--) begin put(cw[8*k +: 8]); c = crc_b(c, cw[8*k +: 8]); end
      do_rstart();
      put({TADDR, 1'b1});
      chk(reg_rd_en == ok, "R8 R6 read request after read address", 64'(reg_rd_en), 64'(ok));
      if (ok) begin
         chk(stretch == 1'b1 && reg_addr == a, "R8 stretch and address",
             {51'd0, stretch, reg_addr}, {52'd1, a});
         @(negedge clk);
         chk(stretch == 1'b1 && reg_rd_en == 1'b0, "R8 stretch held while fetching",
             64'(stretch), 1);
         reg_rd_valid = 1'b1; reg_rdata = data;
         @(negedge clk);
         reg_rd_valid = 1'b0; reg_rdata = '0;
         chk(stretch == 1'b0, "R8 stretch released", 64'(stretch), 0);
      end else begin
         @(negedge clk);
         chk(stretch == 1'b0, "R6 no stretch on illegal read", 64'(stretch), 0);
      end
      for (int k = 0; k <= need + 1; k++) begin
         if (!ok)                     exp = 8'hFF;
         else if (k < need)           begin exp = data[8*k +: 8]; c = crc_b(c, exp); end
         else if (k == need && crcen) exp = c;
         else                         exp = 8'hFF;
         chk(tx_byte == exp, "R9 read byte stream", 64'(tx_byte), 64'(exp));
         do_take();
      end
      do_stop();
      @(negedge clk); @(negedge clk);
      chk(rd_cnt == (ok ? 1 : 0) && wr_cnt == 0, "R11 one read, no write", 64'(rd_cnt), 64'(ok));
      chk(disc_cnt == (ok ? 0 : 1), "R6 discard on illegal read", 64'(disc_cnt), 64'(!ok));
   endtask

   initial begin
      #(5.0 * 150000);
      errors++;
      $display("FAIL R8 watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(reg_wr_en == 0 && reg_rd_en == 0 && discard_valid == 0 && stretch == 0,
          "R3 R8 reset outputs idle", {reg_wr_en, reg_rd_en, discard_valid, stretch}, 0);
      chk(tx_byte == 8'hFF, "R9 idle byte after reset", 64'(tx_byte), 64'hFF);

      // near-exhaustive sweep of length code, CRC enable and byte count
      for (int l = 0; l < 4; l++)
         for (int ce = 0; ce < 2; ce++)
            for (int nb = 0; nb <= 9; nb++)
               wr_pkt(12'(l * 300 + ce * 17 + nb), 4'd0, 4'd0, 2'(l), ce[0], nb, 1'b0, l * 20 + nb);

      // corrupted CRC at the correct length
      for (int l = 0; l < 4; l++)
         wr_pkt(12'hA5A, 4'd0, 4'd0, 2'(l), 1'b1, len_of(2'(l)) + 1, 1'b1, l);

      // sector / page illegal, otherwise valid, also with a wrong length
      wr_pkt(12'h010, 4'd1, 4'd0, 2'b01, 1'b1, 5, 1'b0, 3);
      wr_pkt(12'h020, 4'd0, 4'd8, 2'b00, 1'b0, 2, 1'b0, 4);
      wr_pkt(12'h030, 4'd0, 4'd2, 2'b10, 1'b1, 3, 1'b1, 5);

      // R1: wrong target address
      clear(); do_start(); put({7'h15, 1'b0});
      for (int k = 0; k < 5; k++) put(8'(k));
      do_stop(); @(negedge clk); @(negedge clk);
      chk(wr_cnt == 0 && disc_cnt == 0, "R1 foreign address ignored", 64'(wr_cnt + disc_cnt), 0);

      // R1: read direction on the first byte
      clear(); do_start(); put({TADDR, 1'b1});
      for (int k = 0; k < 5; k++) put(8'(k));
      do_stop(); @(negedge clk); @(negedge clk);
      chk(wr_cnt == 0 && disc_cnt == 0 && rd_cnt == 0, "R1 read bit on first byte ignored",
          64'(wr_cnt + disc_cnt + rd_cnt), 0);

      // R10: stop before the control word is complete
      for (int n = 0; n < 3; n++) begin
         clear(); do_start(); put({TADDR, 1'b0});
         for (int k = 0; k < n; k++) put(8'h00);
         do_stop(); @(negedge clk); @(negedge clk);
         chk(wr_cnt == 0 && disc_cnt == 0, "R10 early stop has no effect", 64'(wr_cnt + disc_cnt), 0);
      end

      // R10: start mid-packet, then a clean write
      clear(); do_start(); put({TADDR, 1'b0}); put(8'h40); put(8'h77); put(8'h12); put(8'h99);
      wr_pkt(12'h3C3, 4'd0, 4'd0, 2'b00, 1'b1, 3, 1'b0, 9);

      // reads over length codes and CRC enable
      for (int l = 0; l < 4; l++)
         for (int ce = 0; ce < 2; ce++)
            rd_pkt(12'(100 * l + ce), 4'd0, 4'd0, 2'(l), ce[0],
                   64'h0123_4567_89AB_CDEF ^ 64'(l * 64'h1111_0000_2222 + ce));

      // illegal read
      rd_pkt(12'h055, 4'd3, 4'd0, 2'b01, 1'b1, 64'hDEAD_BEEF_0000_1111);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule